// File: doc/BRIEF.md
# Sector DMA Transfer Sequencer

This block carries out the data-moving part of a cartridge-disk controller's read and write commands. On a start pulse it takes a snapshot of the controller's registers. The memory address is an 18-bit even address formed from two extension bits and the 16-bit bus address. The transfer length is a 16-bit negative word count. The starting disk position is a sector, a head and a cylinder packed into the disk address word. The block then moves the data one word at a time. The two sides are a memory port with a valid/ready handshake and a sector-storage port with a request/acknowledge handshake that carries a linear byte offset.

Each word is 16 bits. Its low byte belongs at the even memory address and its high byte at the next address. While the transfer runs, the block advances the memory address, the disk offset, the word counter and the disk position. A one-cycle `done` pulse reports the end of the transfer, whether all words have moved or the storage side has reported an error. Command decode, interrupt generation and the storage medium itself sit outside this block.

Top module: `sector_dma_seq`

## Requirements
- R1: A `start` pulse while idle with `cmd` = 5 (write), 6 or 7 (read) sets `busy` in the next cycle. A start with any other `cmd` code is ignored: `busy`, `done`, `mem_valid` and `dsk_req` stay low.
- R2: The word count is N = (65536 − `wcnt_in`) mod 65536. When `wcnt_in` = 0, neither port is used and `done` pulses in the cycle after the start.
- R3: Word k (counting from 0) uses memory address ({`addr_ext`, `bar`} with bit 0 cleared) + 2k, wrapping modulo 2^18.
- R4: The start position is sector = `dar`[5:0], head = `dar`[6], cylinder = `dar`[15:7]. Word k uses disk byte offset (SPT·cylinder·2 + head·SPT + sector)·BPS + 2k, with SPT = 40 and BPS = 256 by default.
- R5: Write (code 5) reads each word from memory (`mem_write` = 0) and then presents the same 16-bit value on `dsk_wdata` with `dsk_write` = 1.
- R6: Read (codes 6 and 7, which behave identically) requests each word from storage (`dsk_write` = 0) and then writes `dsk_rdata` to memory with `mem_write` = 1.
- R7: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_addr` and `mem_wdata` hold their values.
- R8: `wcount` loads `wcnt_in` at the start and increments by 1 for each completed word. It reads 0 after a full transfer.
- R9: Position advances once after every BPS/2 words, and once more after a final partial sector. The sector wraps from SPT−1 to 0 with a head step. The head wraps from 1 to 0 with a cylinder step.
- R10: An acknowledge with `dsk_err` high ends the transfer. The failing word is not counted and does not advance the position, and `done` still pulses.
- R11: `done` is high for exactly one cycle, and `busy` is low in the cycle after it.
- R12: `mem_valid` and `dsk_req` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a command (sampled while idle) |
| cmd | input | 3 | Command code: 5 write, 6/7 read |
| addr_ext | input | 2 | Memory address bits 17:16 |
| bar | input | 16 | Memory address bits 15:0 (bit 0 ignored) |
| dar | input | 16 | Packed start position: cylinder, head, sector |
| wcnt_in | input | 16 | Negative word count |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| wcount | output | 16 | Running word counter |
| sector | output | 6 | Current sector |
| head | output | 1 | Current head |
| cylinder | output | 9 | Current cylinder |
| mem_valid | output | 1 | Memory word request |
| mem_write | output | 1 | 1 = write to memory, 0 = read |
| mem_addr | output | 18 | Even byte address of the word |
| mem_wdata | output | 16 | Word written to memory |
| mem_rdata | input | 16 | Word read from memory |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| dsk_req | output | 1 | Storage word request |
| dsk_write | output | 1 | 1 = write to storage, 0 = read |
| dsk_offset | output | 24 | Linear byte offset of the word |
| dsk_wdata | output | 16 | Word written to storage |
| dsk_rdata | input | 16 | Word read from storage |
| dsk_ack | input | 1 | Storage completes the request this cycle |
| dsk_err | input | 1 | Storage error, valid with dsk_ack |

## Verification
Each transfer direction is run with a different address-derived data pattern on each side, so that a swapped, shifted or stale word shows up as a data mismatch at the exact word index. Runs with back-to-back handshakes are set against runs where memory and storage hold off for several cycles: the first exposes miscounted or skipped words, and the second exposes addresses or data that move during a stall. A 200-word run that starts on the last sector of head 1 checks the sector, head and cylinder rollover and the partial final sector. A run at the top of the 18-bit space checks address wrap, and an odd bus address checks that bit 0 is cleared. Zero-length, error-terminated and unsupported-command starts separate the paths that end without moving data.

// File: rtl/sector_dma_seq.sv
module sector_dma_seq #(
  parameter int SPT   = 40,
  parameter int BPS   = 256,
  parameter int OFF_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [2:0]       cmd,
  input  logic [1:0]       addr_ext,
  input  logic [15:0]      bar,
  input  logic [15:0]      dar,
  input  logic [15:0]      wcnt_in,
  output logic             busy,
  output logic             done,
  output logic [15:0]      wcount,
  output logic [5:0]       sector,
  output logic             head,
  output logic [8:0]       cylinder,
  output logic             mem_valid,
  output logic             mem_write,
  output logic [17:0]      mem_addr,
  output logic [15:0]      mem_wdata,
  input  logic [15:0]      mem_rdata,
  input  logic             mem_ready,
  output logic             dsk_req,
  output logic             dsk_write,
  output logic [OFF_W-1:0] dsk_offset,
  output logic [15:0]      dsk_wdata,
  input  logic [15:0]      dsk_rdata,
  input  logic             dsk_ack,
  input  logic             dsk_err
);

  localparam int WPS  = BPS / 2;
  localparam int WI_W = $clog2(WPS) + 1;

  typedef enum logic [1:0] {S_IDLE, S_MEM, S_DSK, S_FIN} st_t;
  st_t st;

  logic            to_dsk;
  logic [15:0]     buffer;
  logic [WI_W-1:0] widx;
  logic [31:0]     lin;

  wire cmd_ok    = (cmd == 3'd5) || (cmd == 3'd6) || (cmd == 3'd7);
  wire accept    = (st == S_IDLE) && start && cmd_ok;
  wire mem_hs    = (st == S_MEM) && mem_ready;
  wire dsk_hs    = (st == S_DSK) && dsk_ack;
  wire word_done = (to_dsk && dsk_hs && !dsk_err) || (!to_dsk && mem_hs);
  wire last_word = (wcount + 16'd1) == 16'd0;
  wire sec_end   = (widx == WI_W'(WPS - 1)) || last_word;
  wire sec_wrap  = ({1'b0, sector} + 7'd1) >= 7'(SPT);

  assign lin = (32'(SPT) * 32'd2 * 32'(dar[15:7]) + 32'(SPT) * 32'(dar[6]) + 32'(dar[5:0])) * 32'(BPS);

  assign busy      = (st != S_IDLE);
  assign done      = (st == S_FIN);
  assign mem_valid = (st == S_MEM);
  assign dsk_req   = (st == S_DSK);
  assign mem_write = !to_dsk;
  assign dsk_write = to_dsk;
  assign mem_wdata = buffer;
  assign dsk_wdata = buffer;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      to_dsk     <= 1'b0;
      buffer     <= '0;
      widx       <= '0;
      wcount     <= '0;
      sector     <= '0;
      head       <= 1'b0;
      cylinder   <= '0;
      mem_addr   <= '0;
      dsk_offset <= '0;
    end else begin
      case (st)
        S_IDLE: if (accept) begin
          to_dsk     <= (cmd == 3'd5);
          mem_addr   <= {addr_ext, bar[15:1], 1'b0};
          dsk_offset <= lin[OFF_W-1:0];
          wcount     <= wcnt_in;
          sector     <= dar[5:0];
          head       <= dar[6];
          cylinder   <= dar[15:7];
          widx       <= '0;
          if (wcnt_in == 16'd0) st <= S_FIN;
          else                  st <= (cmd == 3'd5) ? S_MEM : S_DSK;
        end
        S_MEM: if (mem_ready && to_dsk) begin
          buffer <= mem_rdata;
          st     <= S_DSK;
        end
        S_DSK: if (dsk_ack) begin
          if (dsk_err)      st <= S_FIN;
          else if (!to_dsk) begin
            buffer <= dsk_rdata;
            st     <= S_MEM;
          end
        end
        default: st <= S_IDLE;
      endcase

      if (word_done) begin
        mem_addr   <= mem_addr + 18'd2;
        dsk_offset <= dsk_offset + OFF_W'(2);
        wcount     <= wcount + 16'd1;
        if (last_word)   st <= S_FIN;
        else             st <= to_dsk ? S_MEM : S_DSK;
        if (sec_end) begin
          widx <= '0;
          if (sec_wrap) begin
            sector <= '0;
            if (head) begin
              head     <= 1'b0;
              cylinder <= cylinder + 9'd1;
            end else begin
              head <= 1'b1;
            end
          end else begin
            sector <= sector + 6'd1;
          end
        end else begin
          widx <= widx + WI_W'(1);
        end
      end
    end
  end

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);

  // R7
  mem_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_wdata));

  // R12
  one_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_valid && dsk_req));

  // R3
  even_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> !mem_addr[0]);

  // R2
  zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && cmd_ok && wcnt_in == 16'd0) |=> done && !mem_valid && !dsk_req);

  // R10
  err_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dsk_req && dsk_ack && dsk_err |=> done && $stable(wcount));

endmodule

// File: tb/tb_sector_dma_seq.sv
`timescale 1ns/1ps
module tb_sector_dma_seq;
  localparam int SPT = 40;
  localparam int BPS = 256;
  localparam int WPS = BPS / 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  cmd = '0;
  logic [1:0]  addr_ext = '0;
  logic [15:0] bar = '0, dar = '0, wcnt_in = '0;
  logic        busy, done;
  logic [15:0] wcount;
  logic [5:0]  sector;
  logic        head;
  logic [8:0]  cylinder;
  logic        mem_valid, mem_write;
  logic [17:0] mem_addr;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata = '0;
  logic        mem_ready = 1'b0;
  logic        dsk_req, dsk_write;
  logic [23:0] dsk_offset;
  logic [15:0] dsk_wdata;
  logic [15:0] dsk_rdata = '0;
  logic        dsk_ack = 1'b0, dsk_err = 1'b0;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  sector_dma_seq #(.SPT(SPT), .BPS(BPS), .OFF_W(24)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd), .addr_ext(addr_ext),
    .bar(bar), .dar(dar), .wcnt_in(wcnt_in), .busy(busy), .done(done),
    .wcount(wcount), .sector(sector), .head(head), .cylinder(cylinder),
    .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .dsk_req(dsk_req), .dsk_write(dsk_write), .dsk_offset(dsk_offset),
    .dsk_wdata(dsk_wdata), .dsk_rdata(dsk_rdata), .dsk_ack(dsk_ack), .dsk_err(dsk_err));

  function automatic logic [15:0] memf(input logic [17:0] a);
    return a[15:0] ^ {a[17:16], 14'h0} ^ 16'h5AC3;
  endfunction

  function automatic logic [15:0] dskf(input logic [23:0] o);
    return {o[7:0], o[15:8]} ^ {8'h0, o[23:16]} ^ 16'h96E1;
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_xfer(input logic [2:0] c, input logic [1:0] ext, input logic [15:0] b,
                          input int cyl, input int hd, input int sec, input logic [15:0] m,
                          input int err_at, input bit stall, input string tag);
    int n, fin, i, guard, mstall, dstall, s, h, cy, adv, seen_done;
    logic [17:0] base, ea;
    logic [23:0] off0, eo;
    bit is_wr;
    n = (65536 - int'(m)) % 65536;
    is_wr = (c == 3'd5);
    base = {ext, b[15:1], 1'b0};
    off0 = 24'((SPT * cyl * 2 + hd * SPT + sec) * BPS);
    i = 0; guard = 0; mstall = 0; dstall = 0; seen_done = 0;
    @(negedge clk);
    cmd = c; addr_ext = ext; bar = b; wcnt_in = m;
    dar = {9'(cyl), 1'(hd), 6'(sec)};
    start = 1'b1;
    while (seen_done == 0 && guard < 5000) begin
      @(negedge clk);
      guard++;
      start = 1'b0;
      mem_ready = 1'b0; dsk_ack = 1'b0; dsk_err = 1'b0;
      if (guard == 1) chk(busy, {tag, " R1 busy after start"}, busy, 1);
      chk(!(mem_valid && dsk_req), {tag, " R12 one port"}, {mem_valid, dsk_req}, 0);
      if (done) begin
        seen_done = 1;
        if (n == 0) chk(guard == 1, {tag, " R2 zero-length done timing"}, guard, 1);
      end
      ea = base + 18'(2 * i);
      eo = off0 + 24'(2 * i);
      if (mem_valid) begin
        chk(i < n, {tag, " R2 no extra memory access"}, i, n);
        chk(mem_addr == ea, {tag, " R3 memory address"}, mem_addr, ea);
        chk(mem_write == !is_wr, is_wr ? {tag, " R5 memory direction"} : {tag, " R6 memory direction"}, mem_write, !is_wr);
        if (!is_wr) chk(mem_wdata == dskf(eo), {tag, " R6 memory write data"}, mem_wdata, dskf(eo));
        if (stall && mstall < 2) mstall++;
        else begin
          mstall = 0;
          mem_ready = 1'b1;
          mem_rdata = memf(mem_addr);
          if (!is_wr) i++;
        end
      end
      if (dsk_req) begin
        chk(i < n, {tag, " R2 no extra storage access"}, i, n);
        chk(dsk_offset == eo, {tag, " R4 storage offset"}, dsk_offset, eo);
        chk(dsk_write == is_wr, is_wr ? {tag, " R5 storage direction"} : {tag, " R6 storage direction"}, dsk_write, is_wr);
        if (is_wr) chk(dsk_wdata == memf(ea), {tag, " R5 storage write data"}, dsk_wdata, memf(ea));
        if (stall && dstall < 1) dstall++;
        else begin
          dstall = 0;
          dsk_ack = 1'b1;
          if (i == err_at) dsk_err = 1'b1;
          else begin
            dsk_rdata = dskf(dsk_offset);
            if (is_wr) i++;
          end
        end
      end
    end
    chk(seen_done == 1, {tag, " R11 done seen"}, seen_done, 1);
    fin = (err_at >= 0) ? err_at : n;
    chk(i == fin, (err_at >= 0) ? {tag, " R10 words before error"} : {tag, " R2 word total"}, i, fin);
    chk(wcount == 16'(int'(m) + fin), (err_at >= 0) ? {tag, " R10 failing word not counted"} : {tag, " R8 word counter"},
        wcount, 16'(int'(m) + fin));
    adv = (err_at >= 0) ? fin / WPS : (n + WPS - 1) / WPS;
    s = sec; h = hd; cy = cyl;
    for (int k = 0; k < adv; k++) begin
      s++;
      if (s >= SPT) begin
        s = 0; h++;
        if (h >= 2) begin h = 0; cy = (cy + 1) % 512; end
      end
    end
    chk(sector == 6'(s), {tag, " R9 sector"}, sector, s);
    chk(head == 1'(h), {tag, " R9 head"}, head, h);
    chk(cylinder == 9'(cy), {tag, " R9 cylinder"}, cylinder, cy);
    @(negedge clk);
    chk(!done && !busy, {tag, " R11 single done pulse"}, {done, busy}, 0);
  endtask

  task automatic t_reset();
    chk(!busy && !done && !mem_valid && !dsk_req, "reset R11 idle outputs", {busy, done, mem_valid, dsk_req}, 0);
  endtask

  task automatic t_ignored(input logic [2:0] c);
    @(negedge clk);
    cmd = c; wcnt_in = 16'hFFF0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 4; k++) begin
      chk(!busy && !done && !mem_valid && !dsk_req, "R1 unsupported code ignored",
          {busy, done, mem_valid, dsk_req}, 0);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    run_xfer(3'd5, 2'd0, 16'h1000, 3, 0, 2, 16'hFFF0, -1, 1'b0, "write_basic");
    run_xfer(3'd6, 2'd1, 16'h2345, 7, 1, 10, 16'hFFF4, -1, 1'b1, "read6_stall");
    run_xfer(3'd7, 2'd1, 16'h2345, 7, 1, 10, 16'hFFF4, -1, 1'b1, "read7_stall");
    run_xfer(3'd5, 2'd2, 16'h0400, 1, 0, 0, 16'h0000, -1, 1'b0, "zero_len");
    run_xfer(3'd6, 2'd0, 16'h8000, 5, 1, 39, 16'hFF38, -1, 1'b0, "rollover");
    run_xfer(3'd5, 2'd0, 16'h0100, 511, 1, 39, 16'hFF7F, -1, 1'b0, "cyl_wrap");
    run_xfer(3'd6, 2'd3, 16'hFFFC, 0, 0, 0, 16'hFFFC, -1, 1'b0, "addr_wrap");
    run_xfer(3'd5, 2'd0, 16'h3000, 2, 0, 5, 16'hFFF0, 5, 1'b1, "write_err");
    run_xfer(3'd7, 2'd0, 16'h3000, 2, 0, 5, 16'hFFF0, 0, 1'b0, "read_err");
    t_ignored(3'd3);
    t_ignored(3'd0);
    run_xfer(3'd6, 2'd0, 16'h0040, 0, 0, 0, 16'hFFFE, -1, 1'b1, "after_ignored");
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule